// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a parallel flash bus and the controller of a flash array. It watches bus write cycles, each qualified by an active-low chip enable and an active-low write enable. It acts on the rising edge of the write enable. Keyed command sequences are recognised from the address and data of successive writes. Every such sequence starts with a two-write unlock prefix. When a sequence completes, the block issues a one-clock request to the array controller: a program request carrying address and data, a whole-array erase request, or a sector erase request carrying the sector number.

The block also tells the read path what a bus read returns. It can return plain array data. In identification mode it returns a maker code or a device code. While an erase is running it returns a status byte. The status byte shows 0 on bit 7 while the erase runs, which the host polls until it reads 1, and a bit 6 that flips every clock. The erase time is modelled by a down-counter. Array reads return by themselves when the counter runs out.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset no request is asserted, `erase_busy` is 0, `rd_array` is 1 and `rd_byte` is 00h.
- R2: A write is taken on the clock where `we_n` is sampled high after being sampled low with `ce_n` low. The resulting request is visible one clock later for exactly one clock, and at most one request is high at a time. A write with `ce_n` high has no effect.
- R3: The unlock prefix is data AAh at U1, then data 55h at U2. In word mode (`byte_mode`=0) U1 is 5555h and U2 is 2AAAh. In byte mode U1 is AAAAh and U2 is 5555h.
- R4: Data F0h at any address returns to array reads, except as the data of an armed program. The unlock prefix followed by F0h at U1 does the same.
- R5: The unlock prefix followed by 90h at U1 enters identification mode: `rd_array`=0, and `rd_byte` is 40h when `rd_a0`=0 and 13h when `rd_a0`=1. The mode lasts until a reset command, an aborted sequence or a completed operation.
- R6: The unlock prefix followed by A0h at U1 arms a program. The next write, whatever its data (F0h included), raises `prog_req` with that write's address and data on `prog_addr`/`prog_data`.
- R7: Unlock, 80h at U1, unlock, then 10h at U1 raises `chip_erase_req`.
- R8: Unlock, 80h at U1, unlock, then 30h at any address raises `sector_erase_req`. `sector_addr` is then the top SECT_W bits of that write's address.
- R9: A write that does not match the step the sequence expects aborts it. No request is issued and array reads resume.
- R10: One clock after an erase request, `erase_busy` is 1 for BUSY_CYCLES clocks. During that time `rd_array`=0 and `rd_byte` has bit 7 = 0, bit 6 flipping every clock, and bits 5..0 = 0. Afterwards `rd_array` is 1 again.
- R11: While `erase_busy` is 1, a completed program or erase sequence issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Bus chip enable, active low |
| we_n | input | 1 | Bus write enable, active low |
| byte_mode | input | 1 | 1 selects byte-mode unlock addresses |
| bus_addr | input | ADDR_W | Write address |
| bus_data | input | 8 | Write data |
| rd_a0 | input | 1 | Lowest read address bit, picks the identification code |
| prog_req | output | 1 | One-clock program request |
| prog_addr | output | ADDR_W | Program address |
| prog_data | output | 8 | Program data |
| chip_erase_req | output | 1 | One-clock whole-array erase request |
| sector_erase_req | output | 1 | One-clock sector erase request |
| sector_addr | output | SECT_W | Sector to erase |
| erase_busy | output | 1 | Erase in progress |
| rd_array | output | 1 | Reads return array data |
| rd_byte | output | 8 | Identification code or status byte when `rd_array` is 0 |

## Verification
The assertions take for granted that every write strobe lasts at least one clock low and one clock high, so two write events can never fall on adjacent clocks. They also assume that address and data stay stable while `we_n` rises. The bench drives each write over three clock periods, changes its inputs only on falling edges, and in the random part waits out every erase it triggers before writing again.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PARM, ST_ESET, ST_EU1, ST_EU2
  } seq_st_t;

  localparam logic [7:0] CMD_KEY1  = 8'hAA;
  localparam logic [7:0] CMD_KEY2  = 8'h55;
  localparam logic [7:0] CMD_RESET = 8'hF0;
  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_ESET  = 8'h80;
  localparam logic [7:0] CMD_CHIP  = 8'h10;
  localparam logic [7:0] CMD_SECT  = 8'h30;
endpackage

// File: rtl/fcd_wr_detect.sv
module fcd_wr_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  output logic wr_evt
);
  logic we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b1;
    else        we_q <= we_n;
  end

  assign wr_evt = !we_q && we_n && !ce_n;
endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm import fcd_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_req,
  output logic              sect_req,
  output logic [SECT_W-1:0] sect_addr,
  output logic              id_mode
);
  localparam logic [ADDR_W-1:0] U1_WORD = ADDR_W'(16'h5555);
  localparam logic [ADDR_W-1:0] U2_WORD = ADDR_W'(16'h2AAA);
  localparam logic [ADDR_W-1:0] U1_BYTE = ADDR_W'(16'hAAAA);
  localparam logic [ADDR_W-1:0] U2_BYTE = ADDR_W'(16'h5555);

  seq_st_t st_q, st_d;
  logic    id_d, prog_d, chip_d, sect_d;
  logic    hit_u1, hit_u2;

  assign hit_u1 = wr_addr == (byte_mode ? U1_BYTE : U1_WORD);
  assign hit_u2 = wr_addr == (byte_mode ? U2_BYTE : U2_WORD);

  always_comb begin
    st_d   = st_q;
    id_d   = id_mode;
    prog_d = 1'b0;
    chip_d = 1'b0;
    sect_d = 1'b0;
    if (wr_evt) begin
      st_d = ST_IDLE;
      id_d = 1'b0;
      if (st_q == ST_PARM) begin
        prog_d = !busy;
      end else if (wr_data != CMD_RESET) begin
        case (st_q)
          ST_IDLE, ST_ESET:
            if (hit_u1 && wr_data == CMD_KEY1) begin
              st_d = (st_q == ST_IDLE) ? ST_U1 : ST_EU1;
              id_d = id_mode;
            end
          ST_U1, ST_EU1:
            if (hit_u2 && wr_data == CMD_KEY2) begin
              st_d = (st_q == ST_U1) ? ST_U2 : ST_EU2;
              id_d = id_mode;
            end
          ST_U2:
            if (hit_u1) begin
              if (wr_data == CMD_IDENT) begin
                id_d = 1'b1;
              end else if (wr_data == CMD_PROG) begin
                st_d = ST_PARM;
                id_d = id_mode;
              end else if (wr_data == CMD_ESET) begin
                st_d = ST_ESET;
                id_d = id_mode;
              end
            end
          ST_EU2:
            if (hit_u1 && wr_data == CMD_CHIP) chip_d = !busy;
            else if (wr_data == CMD_SECT)      sect_d = !busy;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      id_mode  <= 1'b0;
      prog_req <= 1'b0;
      chip_req <= 1'b0;
      sect_req <= 1'b0;
    end else begin
      st_q     <= st_d;
      id_mode  <= id_d;
      prog_req <= prog_d;
      chip_req <= chip_d;
      sect_req <= sect_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_addr <= '0;
      prog_data <= '0;
      sect_addr <= '0;
    end else begin
      if (prog_d) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (sect_d) sect_addr <= wr_addr[ADDR_W-1 -: SECT_W];
    end
  end
endmodule

// File: rtl/fcd_busy_timer.sv
module fcd_busy_timer #(
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic toggle
);
  localparam int              CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             tog_d;

  assign busy = cnt_q != '0;

  always_comb begin
    cnt_d = cnt_q;
    tog_d = toggle;
    if (start)     cnt_d = LOAD;
    else if (busy) cnt_d = cnt_q - 1'b1;
    if (busy)      tog_d = !toggle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      toggle <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      toggle <= tog_d;
    end
  end
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux #(
  parameter logic [7:0] MANUF_ID  = 8'h40,
  parameter logic [7:0] DEVICE_ID = 8'h13
) (
  input  logic       id_mode,
  input  logic       busy,
  input  logic       toggle,
  input  logic       rd_a0,
  output logic       rd_array,
  output logic [7:0] rd_byte
);
  always_comb begin
    rd_array = !busy && !id_mode;
    if (busy)         rd_byte = {1'b0, toggle, 6'b0};
    else if (id_mode) rd_byte = rd_a0 ? DEVICE_ID : MANUF_ID;
    else              rd_byte = 8'h00;
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W      = 16,
  parameter int         SECT_W      = 4,
  parameter int         BUSY_CYCLES = 1000,
  parameter logic [7:0] MANUF_ID    = 8'h40,
  parameter logic [7:0] DEVICE_ID   = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              byte_mode,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_data,
  input  logic              rd_a0,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              chip_erase_req,
  output logic              sector_erase_req,
  output logic [SECT_W-1:0] sector_addr,
  output logic              erase_busy,
  output logic              rd_array,
  output logic [7:0]        rd_byte
);
  logic [1:0] rst_sync;
  logic       rst_int_n, wr_evt, id_mode, toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  fcd_wr_detect u_wr (
    .clk(clk), .rst_n(rst_int_n), .ce_n(ce_n), .we_n(we_n), .wr_evt(wr_evt)
  );

  fcd_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .wr_evt(wr_evt), .byte_mode(byte_mode),
    .wr_addr(bus_addr), .wr_data(bus_data), .busy(erase_busy),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_req(chip_erase_req), .sect_req(sector_erase_req),
    .sect_addr(sector_addr), .id_mode(id_mode)
  );

  fcd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_int_n), .start(chip_erase_req || sector_erase_req),
    .busy(erase_busy), .toggle(toggle)
  );

  fcd_read_mux #(.MANUF_ID(MANUF_ID), .DEVICE_ID(DEVICE_ID)) u_rd (
    .id_mode(id_mode), .busy(erase_busy), .toggle(toggle), .rd_a0(rd_a0),
    .rd_array(rd_array), .rd_byte(rd_byte)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       prog_req,
  input logic       chip_erase_req,
  input logic       sector_erase_req,
  input logic       erase_busy,
  input logic       rd_array,
  input logic [7:0] rd_byte
);
  logic any_req;
  assign any_req = prog_req || chip_erase_req || sector_erase_req;

  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sector_erase_req}));

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> !any_req);

  assert_no_prog_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> !erase_busy);

  assert_erase_sets_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_erase_req || sector_erase_req) |=> erase_busy);

  assert_busy_rise_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_busy) |-> $past(chip_erase_req || sector_erase_req));

  assert_busy_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    erase_busy |-> (!rd_array && !rd_byte[7]));
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .chip_erase_req(chip_erase_req),
  .sector_erase_req(sector_erase_req), .erase_busy(erase_busy),
  .rd_array(rd_array), .rd_byte(rd_byte)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;
  localparam int AW = 16, SW = 4, BUSY = 48;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, byte_mode = 1'b0, rd_a0 = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_data = '0;
  logic          prog_req, chip_erase_req, sector_erase_req, erase_busy, rd_array;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data, rd_byte;
  logic [SW-1:0] sector_addr;

  flash_cmd_decoder #(.ADDR_W(AW), .SECT_W(SW), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .byte_mode(byte_mode),
    .bus_addr(bus_addr), .bus_data(bus_data), .rd_a0(rd_a0),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .sector_erase_req(sector_erase_req),
    .sector_addr(sector_addr), .erase_busy(erase_busy),
    .rd_array(rd_array), .rd_byte(rd_byte)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int m_st = 0;
  bit m_id = 0, m_busy = 0;
  logic s_prog, s_chip, s_sect, s_arr;
  logic [AW-1:0] s_paddr;
  logic [7:0]    s_pdata;
  logic [SW-1:0] s_saddr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected result of one write: 0 none, 1 program, 2 chip erase, 3 sector erase
  task automatic model_step(input logic [15:0] a, input logic [7:0] d, output int e);
    logic [15:0] u1, u2;
    int nst;
    bit nid;
    u1 = byte_mode ? 16'hAAAA : 16'h5555;
    u2 = byte_mode ? 16'h5555 : 16'h2AAA;
    e = 0; nst = 0; nid = 0;
    if (m_st == 3) e = m_busy ? 0 : 1;
    else if (d != 8'hF0) begin
      case (m_st)
        0: if (a == u1 && d == 8'hAA) begin nst = 1; nid = m_id; end
        4: if (a == u1 && d == 8'hAA) begin nst = 5; nid = m_id; end
        1: if (a == u2 && d == 8'h55) begin nst = 2; nid = m_id; end
        5: if (a == u2 && d == 8'h55) begin nst = 6; nid = m_id; end
        2: if (a == u1) begin
             if (d == 8'h90) nid = 1;
             else if (d == 8'hA0) begin nst = 3; nid = m_id; end
             else if (d == 8'h80) begin nst = 4; nid = m_id; end
           end
        6: if (a == u1 && d == 8'h10) e = m_busy ? 0 : 2;
           else if (d == 8'h30) e = m_busy ? 0 : 3;
        default: ;
      endcase
    end
    m_st = nst; m_id = nid;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input bit ce);
    @(negedge clk); ce_n = !ce; we_n = 1'b0; bus_addr = a; bus_data = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    s_prog = prog_req; s_chip = chip_erase_req; s_sect = sector_erase_req;
    s_arr = rd_array; s_paddr = prog_addr; s_pdata = prog_data; s_saddr = sector_addr;
    ce_n = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
    int e;
    bit pre_busy;
    pre_busy = m_busy;
    model_step(a, d, e);
    wr(a, d, 1'b1);
    chk(s_prog == (e == 1), req, s_prog, e == 1);
    chk(s_chip == (e == 2), req, s_chip, e == 2);
    chk(s_sect == (e == 3), req, s_sect, e == 3);
    chk(s_arr == (!m_id && !pre_busy), req, s_arr, !m_id && !pre_busy);
    if (e == 1) begin
      chk(s_paddr == a, req, s_paddr, a);
      chk(s_pdata == d, req, s_pdata, d);
    end
    if (e == 3) chk(s_saddr == a[15:12], req, s_saddr, a[15:12]);
    if ((e == 2 || e == 3) && !m_busy && req == "R3") begin
      repeat (BUSY + 5) @(negedge clk);
    end
  endtask

  task automatic unlock(input string req);
    logic [15:0] u1, u2;
    u1 = byte_mode ? 16'hAAAA : 16'h5555;
    u2 = byte_mode ? 16'h5555 : 16'h2AAA;
    do_write(u1, 8'hAA, req);
    do_write(u2, 8'h55, req);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic t6;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!prog_req && !chip_erase_req && !sector_erase_req, "R1", prog_req, 0);
    chk(!erase_busy, "R1", erase_busy, 0);
    chk(rd_array, "R1", rd_array, 1);
    chk(rd_byte == 8'h00, "R1", rd_byte, 8'h00);

    // R2 write with ce_n high is ignored: the following 90h must not enter ID mode
    wr(16'h5555, 8'hAA, 1'b0);
    do_write(16'h2AAA, 8'h55, "R2");
    do_write(16'h5555, 8'h90, "R2");

    // R6 word-mode program, then program with F0h data
    unlock("R3"); do_write(16'h5555, 8'hA0, "R6"); do_write(16'h1234, 8'h5A, "R6");
    unlock("R6"); do_write(16'h5555, 8'hA0, "R6"); do_write(16'h0F00, 8'hF0, "R6");

    // R5 identification codes
    unlock("R5"); do_write(16'h5555, 8'h90, "R5");
    rd_a0 = 1'b0; #1;
    chk(rd_byte == 8'h40 && !rd_array, "R5", rd_byte, 8'h40);
    rd_a0 = 1'b1; #1;
    chk(rd_byte == 8'h13 && !rd_array, "R5", rd_byte, 8'h13);

    // R4 single-write reset and three-write reset
    do_write(16'h3333, 8'hF0, "R4");
    unlock("R4"); do_write(16'h5555, 8'h90, "R4");
    unlock("R4"); do_write(16'h5555, 8'hF0, "R4");

    // R9 mismatched second unlock write aborts; later writes do not program
    do_write(16'h5555, 8'hAA, "R9"); do_write(16'h2AAB, 8'h55, "R9");
    do_write(16'h5555, 8'hA0, "R9"); do_write(16'h1111, 8'h22, "R9");

    // R7 byte-mode chip erase, R10 busy window
    byte_mode = 1'b1;
    unlock("R7"); do_write(16'hAAAA, 8'h80, "R7");
    unlock("R7"); do_write(16'hAAAA, 8'h10, "R7");
    m_busy = 1;
    @(negedge clk);
    chk(erase_busy, "R10", erase_busy, 1);
    chk(!rd_array, "R10", rd_array, 0);
    chk(rd_byte[7] == 1'b0 && rd_byte[5:0] == 6'd0, "R10", rd_byte, 0);
    t6 = rd_byte[6];
    @(negedge clk);
    chk(rd_byte[6] == !t6, "R10", rd_byte[6], !t6);

    // R11 program and erase during busy issue nothing
    unlock("R11"); do_write(16'hAAAA, 8'hA0, "R11"); do_write(16'h4444, 8'h77, "R11");
    unlock("R11"); do_write(16'hAAAA, 8'h80, "R11");
    unlock("R11"); do_write(16'h7000, 8'h30, "R11");
    repeat (BUSY + 5) @(negedge clk);
    m_busy = 0;
    chk(!erase_busy, "R10", erase_busy, 0);
    chk(rd_array, "R10", rd_array, 1);

    // R8 sector erase with sector number from top address bits
    byte_mode = 1'b0;
    unlock("R8"); do_write(16'h5555, 8'h80, "R8");
    unlock("R8"); do_write(16'hB123, 8'h30, "R8");
    repeat (BUSY + 5) @(negedge clk);

    // random sequences drawn from a pool that often completes commands (R3, R9)
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      int sel;
      byte_mode = ($urandom_range(0, 7) == 0) ? ~byte_mode : byte_mode;
      sel = $urandom_range(0, 4);
      a = (sel < 2) ? (byte_mode ? 16'hAAAA : 16'h5555) :
          (sel == 2) ? (byte_mode ? 16'h5555 : 16'h2AAA) : 16'($urandom);
      case ($urandom_range(0, 9))
        0, 1: d = 8'hAA;
        2, 3: d = 8'h55;
        4: d = 8'h90;
        5: d = 8'hA0;
        6: d = 8'h80;
        7: d = 8'h10;
        8: d = 8'h30;
        default: d = ($urandom_range(0, 1) == 0) ? 8'hF0 : 8'($urandom);
      endcase
      do_write(a, d, "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule